// File: doc/BRIEF.md
# Sixteen-Bit External Bus Access Adapter

This block connects a 32-bit internal request port to an external memory bus whose data path is only 16 bits wide. A request carries a byte address, an access size (byte, word or longword), a read/write flag and 32 bits of write data. The adapter turns it into one or two external cycles. It drives a halfword-aligned address, places the data on the correct big-endian byte lanes, and produces active-low strobes. A longword becomes two ordered external cycles, and read data is assembled into a 32-bit response.

A mode input, sampled when a request is accepted, picks one of two strobe styles. In the per-lane style each byte lane has its own write strobe. In the single-strobe style one write strobe marks every write, and separate active-low byte-valid outputs mark which lanes carry data. Requests whose size does not fit their address alignment are refused with a one-clock error pulse and start no external cycle.

The controller has four states. IDLE accepts requests. ACTIVE holds one external cycle for `CYC_CLKS` clocks. GAP is a single clock with all strobes high between the two halves of a longword. FINISH presents the response for one clock. The transitions are:
- accept: IDLE to ACTIVE, on a valid, aligned request.
- refuse: IDLE to IDLE, on a misaligned request or a reserved size, with the error pulse.
- split: ACTIVE to GAP, at the end of the first half of a longword.
- resume: GAP to ACTIVE.
- complete: ACTIVE to FINISH, at the end of the final cycle.
- release: FINISH to IDLE.

Top module: `ext16_bus_adapter`

## Requirements
- R1: `ext_addr[0]` is always 0. During a cycle, `ext_addr[ADDR_W-1:1]` equals the request address bits ADDR_W-1..1, except that bit 1 is forced to 1 in the second half of a longword.
- R2: The `req_size` encoding is 0 for byte, 1 for word, 2 for longword and 3 reserved. A byte at an even address uses lane `ext_dout[15:8]`. A byte at an odd address uses lane `ext_dout[7:0]`. A byte write carries `req_wdata[7:0]` on that lane. A byte read returns that lane of `ext_din` in `rsp_rdata[7:0]`, with `rsp_rdata[31:8]` zero.
- R3: With `strobe_mode`=0, a write drives `ext_wr_n[1]` low when the upper lane is used and `ext_wr_n[0]` low when the lower lane is used. Word and longword writes drive both low. All of `ext_bc_n` stays high.
- R4: With `strobe_mode`=1, every write drives `ext_wr_n[1]` low and keeps `ext_wr_n[0]` high. `ext_bc_n[1:0]` takes the low-active lane pattern that R3 gives for `ext_wr_n[1:0]`.
- R5: `ext_wr_n[3:2]` and `ext_bc_n[3:2]` are always high. A read cycle drives `ext_rd_n` low and keeps every write strobe and byte-valid output high.
- R6: A longword runs two cycles. The first is at offset 0 and carries `req_wdata[31:16]`. The second is at offset 2 and carries `req_wdata[15:0]`. Both lanes are active in both cycles, and all strobes are high for exactly one clock between the two cycles.
- R7: On a longword read, the first halfword lands in `rsp_rdata[31:16]` and the second in `rsp_rdata[15:0]`. A word read returns `{16'h0, ext_din}`.
- R8: Each external cycle holds its address, data and strobes for exactly `CYC_CLKS` clocks. `req_ready` is low from acceptance until the release transition. `rsp_valid` is high for one clock, the clock after the final cycle ends.
- R9: A word at an odd address, a longword whose address bits 1:0 are not zero, or size 3 is refused. `req_err` goes high for one clock, no strobe or read strobe goes low, and `req_ready` stays high.
- R10: After reset, `req_ready` is high and all strobes, byte-valid outputs and `ext_rd_n` are high. `req_err` and `rsp_valid` are low, and `ext_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned for bytes and words |
| strobe_mode | input | 1 | 0 per-lane write strobes, 1 single strobe plus byte-valid |
| req_err | output | 1 | One-clock pulse on a refused request |
| rsp_valid | output | 1 | One-clock pulse when the access has finished |
| rsp_rdata | output | 32 | Assembled read data |
| ext_addr | output | ADDR_W | External address, bit 0 always low |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 4 | Write strobes, active low; only bits 1:0 are used |
| ext_bc_n | output | 4 | Byte-valid outputs, active low; only bits 1:0 are used |

## Verification
The bench builds the adapter with `ADDR_W` at its default of 28, so an address with bit 27 set checks that the top address bit is carried through. It sets `CYC_CLKS` to 2, so every external cycle spans more than one clock. This shows that address, data and strobes are held across the whole cycle, and it keeps the longword gap and the response pulse timing visible. Both strobe modes are run with every byte offset, with word and longword transfers, and with reads whose assembled result depends on the order of the halves.

// File: rtl/ext16_pkg.sv
package ext16_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_GAP,
        ST_FINISH
    } bus_state_e;

    typedef struct packed {
        logic [3:0] wr_n;
        logic [3:0] bc_n;
        logic       rd_n;
    } strobe_t;

    localparam strobe_t STRB_QUIET = '{wr_n: 4'hF, bc_n: 4'hF, rd_n: 1'b1};

endpackage

// File: rtl/ext16_lane_map.sv
module ext16_lane_map
    import ext16_pkg::*;
(
    input  acc_size_e   size,
    input  logic        byte_odd,
    input  logic        second_half,
    input  logic        single_mode,
    input  logic        is_write,
    input  logic [31:0] wdata,
    output strobe_t     strb,
    output logic [15:0] dout
);

    logic use_hi;
    logic use_lo;

    // lane usage: even byte -> upper lane, odd byte -> lower lane
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                use_hi = ~byte_odd;
                use_lo = byte_odd;
            end
            default: begin
                use_hi = 1'b1;
                use_lo = 1'b1;
            end
        endcase
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: dout = {wdata[7:0], wdata[7:0]};
            SZ_WORD: dout = wdata[15:0];
            SZ_LONG: dout = second_half ? wdata[15:0] : wdata[31:16];
            default: dout = 16'h0000;
        endcase
    end

    always_comb begin
        strb = STRB_QUIET;
        if (is_write) begin
            if (single_mode) begin
                strb.wr_n[1] = 1'b0;
                strb.bc_n[1] = ~use_hi;
                strb.bc_n[0] = ~use_lo;
            end else begin
                strb.wr_n[1] = ~use_hi;
                strb.wr_n[0] = ~use_lo;
            end
        end else begin
            strb.rd_n = 1'b0;
        end
    end

endmodule

// File: rtl/ext16_cycle_timer.sv
module ext16_cycle_timer #(
    parameter int CYC_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    generate
        if (CYC_CLKS <= 1) begin : g_single
            assign last = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(CYC_CLKS);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_CLKS - 1);
            logic [CNT_W-1:0] cnt_q;

            assign last = run && (cnt_q == CNT_LAST);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run || last) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ext16_read_gather.sv
module ext16_read_gather
    import ext16_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture,
    input  logic        second_half,
    input  acc_size_e   size,
    input  logic        byte_odd,
    input  logic [15:0] din,
    output logic [31:0] rdata
);

    logic [15:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            rdata <= '0;
        end else if (capture) begin
            if (size == SZ_LONG && !second_half) begin
                hi_q <= din;
            end else begin
                unique case (size)
                    SZ_BYTE: rdata <= {24'h0, byte_odd ? din[7:0] : din[15:8]};
                    SZ_WORD: rdata <= {16'h0, din};
                    SZ_LONG: rdata <= {hi_q, din};
                    default: rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ext16_bus_adapter.sv
module ext16_bus_adapter
    import ext16_pkg::*;
#(
    parameter int ADDR_W   = 28,
    parameter int CYC_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic              strobe_mode,
    output logic              req_err,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [15:0]       ext_dout,
    input  logic [15:0]       ext_din,
    output logic              ext_rd_n,
    output logic [3:0]        ext_wr_n,
    output logic [3:0]        ext_bc_n
);

    bus_state_e state_q, state_d;

    // request context latched at accept
    logic [ADDR_W-1:0] addr_q;
    acc_size_e         size_q;
    logic              wr_q;
    logic              mode_q;
    logic [31:0]       wdata_q;
    logic              second_q, second_d;

    // registered outputs
    strobe_t           strb_q;
    logic [15:0]       dout_q;
    logic [ADDR_W-1:0] eaddr_q;
    logic              err_q;
    logic              rsp_q;

    acc_size_e req_sz;
    logic      accept;
    logic      misfit;
    logic      start;
    logic      cyc_last;

    assign req_sz = acc_size_e'(req_size);
    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        unique case (req_sz)
            SZ_BYTE: misfit = 1'b0;
            SZ_WORD: misfit = req_addr[0];
            SZ_LONG: misfit = |req_addr[1:0];
            default: misfit = 1'b1;
        endcase
    end

    assign start = accept && !misfit;

    ext16_cycle_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_ACTIVE),
        .last  (cyc_last)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        second_d = second_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_ACTIVE;
                    second_d = 1'b0;
                end
            end
            ST_ACTIVE: begin
                if (cyc_last) begin
                    if (size_q == SZ_LONG && !second_q) begin
                        state_d = ST_GAP;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_GAP: begin
                state_d  = ST_ACTIVE;
                second_d = 1'b1;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            second_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            second_q <= second_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            wr_q    <= 1'b0;
            mode_q  <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            size_q  <= req_sz;
            wr_q    <= req_write;
            mode_q  <= strobe_mode;
            wdata_q <= req_wdata;
        end
    end

    // context for the cycle about to be driven
    logic [ADDR_W-1:0] ctx_addr;
    acc_size_e         ctx_size;
    logic              ctx_wr;
    logic              ctx_mode;
    logic [31:0]       ctx_wdata;
    strobe_t           map_strb;
    logic [15:0]       map_dout;
    logic [ADDR_W-1:0] next_eaddr;

    assign ctx_addr  = start ? req_addr    : addr_q;
    assign ctx_size  = start ? req_sz      : size_q;
    assign ctx_wr    = start ? req_write   : wr_q;
    assign ctx_mode  = start ? strobe_mode : mode_q;
    assign ctx_wdata = start ? req_wdata   : wdata_q;

    assign next_eaddr = {ctx_addr[ADDR_W-1:2], (second_d | ctx_addr[1]), 1'b0};

    ext16_lane_map u_map (
        .size        (ctx_size),
        .byte_odd    (ctx_addr[0]),
        .second_half (second_d),
        .single_mode (ctx_mode),
        .is_write    (ctx_wr),
        .wdata       (ctx_wdata),
        .strb        (map_strb),
        .dout        (map_dout)
    );

    ext16_read_gather u_gather (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (cyc_last && !wr_q),
        .second_half (second_q),
        .size        (size_q),
        .byte_odd    (addr_q[0]),
        .din         (ext_din),
        .rdata       (rsp_rdata)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q  <= STRB_QUIET;
            dout_q  <= '0;
            eaddr_q <= '0;
            err_q   <= 1'b0;
            rsp_q   <= 1'b0;
        end else begin
            err_q <= accept && misfit;
            rsp_q <= (state_d == ST_FINISH);
            if (state_d == ST_ACTIVE) begin
                strb_q  <= map_strb;
                dout_q  <= map_dout;
                eaddr_q <= next_eaddr;
            end else begin
                strb_q <= STRB_QUIET;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign req_err   = err_q;
    assign rsp_valid = rsp_q;
    assign ext_addr  = eaddr_q;
    assign ext_dout  = dout_q;
    assign ext_rd_n  = strb_q.rd_n;
    assign ext_wr_n  = strb_q.wr_n;
    assign ext_bc_n  = strb_q.bc_n;

endmodule

// File: rtl/ext16_bus_adapter_chk.sv
module ext16_bus_adapter_chk #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_err,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_rd_n,
    input logic [3:0]        ext_wr_n,
    input logic [3:0]        ext_bc_n
);

    AST_ADDR_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ext_addr[0] == 1'b0); // R1

    AST_HIGH_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (&ext_wr_n[3:2]) && (&ext_bc_n[3:2])); // R5

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> ((&ext_wr_n) && (&ext_bc_n))); // R5

    AST_BYTEVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_bc_n[1:0] != 2'b11) |-> (!ext_wr_n[1] && ext_wr_n[0])); // R4

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err); // R9

    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && ext_rd_n && (&ext_wr_n))); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !(&ext_wr_n)) |-> !req_ready); // R8

endmodule

bind ext16_bus_adapter ext16_bus_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_err   (req_err),
    .rsp_valid (rsp_valid),
    .ext_addr  (ext_addr),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .ext_bc_n  (ext_bc_n)
);

// File: tb/test_ext16_bus_adapter.sv
`timescale 1ns/1ps
module test_ext16_bus_adapter;

    localparam int ADDR_W   = 28;
    localparam int CYC_CLKS = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              strobe_mode = 1'b0;
    logic              req_err;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [ADDR_W-1:0] ext_addr;
    logic [15:0]       ext_dout;
    logic [15:0]       ext_din = '0;
    logic              ext_rd_n;
    logic [3:0]        ext_wr_n;
    logic [3:0]        ext_bc_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ext16_bus_adapter #(.ADDR_W(ADDR_W), .CYC_CLKS(CYC_CLKS)) i_ext16_bus_adapter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .strobe_mode (strobe_mode),
        .req_err     (req_err),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .ext_addr    (ext_addr),
        .ext_dout    (ext_dout),
        .ext_din     (ext_din),
        .ext_rd_n    (ext_rd_n),
        .ext_wr_n    (ext_wr_n),
        .ext_bc_n    (ext_bc_n)
    );

    typedef struct packed {
        logic [27:0] a;
        logic [1:0]  sz;
        logic        wr;
        logic        md;
        logic [31:0] wd;
        logic [15:0] d0;
        logic [15:0] d1;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{28'h0000100, 2'd0, 1'b1, 1'b0, 32'h000000A5, 16'h0, 16'h0, 32'h0},
        '{28'h0000101, 2'd0, 1'b1, 1'b0, 32'h0000003C, 16'h0, 16'h0, 32'h0},
        '{28'h0000102, 2'd0, 1'b1, 1'b1, 32'h0000005A, 16'h0, 16'h0, 32'h0},
        '{28'h0000103, 2'd0, 1'b1, 1'b1, 32'h000000C3, 16'h0, 16'h0, 32'h0},
        '{28'h0000204, 2'd1, 1'b1, 1'b0, 32'h0000BEEF, 16'h0, 16'h0, 32'h0},
        '{28'h0000206, 2'd1, 1'b1, 1'b1, 32'h00001234, 16'h0, 16'h0, 32'h0},
        '{28'h8000008, 2'd2, 1'b1, 1'b0, 32'hDEADBEEF, 16'h0, 16'h0, 32'h0},
        '{28'h000030C, 2'd2, 1'b1, 1'b1, 32'hCAFEF00D, 16'h0, 16'h0, 32'h0},
        '{28'h0000401, 2'd0, 1'b0, 1'b0, 32'h0, 16'h77AB, 16'h0, 32'h000000AB},
        '{28'h0000402, 2'd0, 1'b0, 1'b1, 32'h0, 16'h9ABC, 16'h0, 32'h0000009A},
        '{28'h0000406, 2'd1, 1'b0, 1'b0, 32'h0, 16'h1357, 16'h0, 32'h00001357},
        '{28'hFFFFFF8, 2'd2, 1'b0, 1'b1, 32'h0, 16'h2468, 16'hACE0, 32'h2468ACE0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // expected {wr_n, bc_n, rd_n} from R3/R4/R5
    function automatic logic [8:0] exp_strb(input vec_t v);
        logic hi, lo;
        logic [3:0] w, b;
        hi = (v.sz == 2'd0) ? ~v.a[0] : 1'b1;
        lo = (v.sz == 2'd0) ?  v.a[0] : 1'b1;
        w = 4'hF;
        b = 4'hF;
        if (!v.wr) return {w, b, 1'b0};
        if (v.md) begin
            w[1] = 1'b0;
            b[1] = ~hi;
            b[0] = ~lo;
        end else begin
            w[1] = ~hi;
            w[0] = ~lo;
        end
        return {w, b, 1'b1};
    endfunction

    task automatic run_vec(input vec_t v);
        int halves;
        logic [27:0] ea;
        halves = (v.sz == 2'd2) ? 2 : 1;
        @(negedge clk);
        chk("R8 ready before accept", {63'h0, req_ready}, 64'h1);
        req_valid   = 1'b1;
        req_addr    = v.a;
        req_size    = v.sz;
        req_write   = v.wr;
        req_wdata   = v.wd;
        strobe_mode = v.md;
        @(posedge clk);
        for (int h = 0; h < halves; h++) begin
            @(negedge clk);
            req_valid = 1'b0;
            ext_din   = (h == 0) ? v.d0 : v.d1;
            ea = {v.a[27:2], (h == 1) ? 1'b1 : v.a[1], 1'b0};
            for (int c = 0; c < CYC_CLKS; c++) begin
                if (c > 0) @(negedge clk);
                chk("R1 R6 address", {36'h0, ext_addr}, {36'h0, ea});
                chk("R3 R4 R5 strobes", {55'h0, ext_wr_n, ext_bc_n, ext_rd_n},
                    {55'h0, exp_strb(v)});
                chk("R8 ready low while busy", {63'h0, req_ready}, 64'h0);
                if (v.wr) begin
                    if (v.sz == 2'd0 && v.a[0])
                        chk("R2 odd byte lane", {56'h0, ext_dout[7:0]}, {56'h0, v.wd[7:0]});
                    else if (v.sz == 2'd0)
                        chk("R2 even byte lane", {56'h0, ext_dout[15:8]}, {56'h0, v.wd[7:0]});
                    else if (v.sz == 2'd1)
                        chk("R2 word data", {48'h0, ext_dout}, {48'h0, v.wd[15:0]});
                    else
                        chk("R6 longword half data", {48'h0, ext_dout},
                            {48'h0, (h == 0) ? v.wd[31:16] : v.wd[15:0]});
                end
            end
            @(negedge clk);
            if (h == 0 && halves == 2) begin
                chk("R6 gap strobes high", {55'h0, ext_wr_n, ext_bc_n, ext_rd_n}, 64'h1FF);
                chk("R8 no response in gap", {63'h0, rsp_valid}, 64'h0);
            end
        end
        chk("R8 response pulse", {63'h0, rsp_valid}, 64'h1);
        chk("R8 strobes released", {55'h0, ext_wr_n, ext_bc_n, ext_rd_n}, 64'h1FF);
        if (!v.wr) chk("R2 R7 read data", {32'h0, rsp_rdata}, {32'h0, v.exp_rd});
        @(negedge clk);
        chk("R8 pulse ends and ready returns", {62'h0, rsp_valid, req_ready}, 64'h1);
    endtask

    task automatic run_bad(input logic [27:0] a, input logic [1:0] sz, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        req_write = 1'b1;
        req_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk({"R9 err pulse ", tag}, {62'h0, req_err, req_ready}, 64'h3);
        chk({"R9 no strobes ", tag}, {55'h0, ext_wr_n, ext_bc_n, ext_rd_n}, 64'h1FF);
        @(negedge clk);
        chk({"R9 err one clock ", tag}, {62'h0, req_err, rsp_valid}, 64'h0);
        chk({"R9 still no strobes ", tag}, {55'h0, ext_wr_n, ext_bc_n, ext_rd_n}, 64'h1FF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 ready after reset", {63'h0, req_ready}, 64'h1);
        chk("R10 strobes after reset", {55'h0, ext_wr_n, ext_bc_n, ext_rd_n}, 64'h1FF);
        chk("R10 pulses low after reset", {62'h0, req_err, rsp_valid}, 64'h0);
        chk("R10 address after reset", {36'h0, ext_addr}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R9: refused requests
        run_bad(28'h0000211, 2'd1, "odd word");
        run_bad(28'h0000502, 2'd2, "longword offset 2");
        run_bad(28'h0000501, 2'd2, "longword offset 1");
        run_bad(28'h0000500, 2'd3, "reserved size");

        // an accepted access right after a refusal still works
        run_vec(VECS[7]);

        finish_run();
    end

endmodule